// File: doc/BRIEF.md
# Trace Line Readout Controller

This block keeps a circular store of 64-bit trace lines and lets a bus master read them back, sixteen bits at a time, through a single data register. While the module is armed, the capture side writes each offered line at the next position, wraps at the end of the store, counts valid lines up to the store depth and raises an overflow flag once an older line is overwritten.

After the module is disarmed, readout stays locked until software makes one aligned word write to the data register. That write also rewinds the read position to the oldest stored line. Each line is then returned as four word reads, the most significant word first, and the lines come out oldest first. Readout is refused while the module is armed, while every trace source is disabled, or while the system is secured. A refused read, a byte read or a misaligned read returns zero and leaves the read position where it was. A separate count register reports the line count and the overflow flag. It can always be read, and reading data does not change it.

Top module: `trace_readout`

## Requirements
- R1: While `arm_i` is high, each cycle with `cap_valid_i` high stores `cap_line_i` at the current write position, which then steps by one and wraps from DEPTH-1 to 0.
- R2: A read of the count register (`bus_reg_i`=1) returns the valid-line count in the low bits and the overflow flag in bit 15, with all other bits zero. The count stops at DEPTH. The overflow flag sets when a line is stored while the count already equals DEPTH.
- R3: A rising edge of `arm_i` clears the count, the overflow flag and the write position.
- R4: A data register read while readout is locked returns zero and leaves the read position unchanged. Readout is locked while armed, while `src_en_i` is all zero, while `secure_i` is high, or when no unlocking write has happened since the last arm.
- R5: A write to the data register with `bus_odd_i`=0 and `bus_byte_i`=0 while `arm_i` is low unlocks readout. It also moves the read position to word 0 of the oldest line, whatever the position was before.
- R6: A data register read with `bus_byte_i`=1 or `bus_odd_i`=1 returns zero and does not move the read position.
- R7: Each line is returned by four successive granted reads in the order bits 63:48, 47:32, 31:16 and 15:0. After the fourth read the position moves to the next line, and it wraps from line DEPTH-1 to line 0.
- R8: The oldest line is line 0 when no overflow occurred. After an overflow it is the line at the current write position.
- R9: A byte or misaligned write to the data register, and any data write while armed, neither unlocks readout nor moves the read position.
- R10: Reading data does not change the count register, and the count register can be read whether readout is locked or not.
- R11: Every read request gives `rd_valid_o` high with its data on `rd_data_o` in the following cycle, and `rd_valid_o` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Module armed; capture runs and readout is locked |
| src_en_i | input | SRC_N | Trace source enables; readout needs at least one set |
| secure_i | input | 1 | System secured; readout locked |
| cap_valid_i | input | 1 | Capture line offered this cycle |
| cap_line_i | input | 64 | Captured trace line |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_reg_i | input | 1 | 0 = trace data register, 1 = count register |
| bus_odd_i | input | 1 | Address bit 0 (misaligned when 1) |
| bus_byte_i | input | 1 | Byte-size access when 1 |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 16 | Read response data |

## Verification
The readout is tried after a session that wrapped the store and after a short session that did not. This separates the two starting lines of the oldest-first order, and in the short session it shows that reads past the count run into lines left from the earlier session. Granted word reads are mixed with byte reads, odd-address reads, security and source-enable changes, and rewinding writes. Each of these is checked against a reference pointer, so that a stray advance is caught as well as a missed one. Random sessions of 1 to 20 lines vary the wrap point, and directed writes made while armed or in a narrow size show that only the aligned write unlocks.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int WORD_W         = 16;
  localparam int WORDS_PER_LINE = 4;
  localparam int LINE_W         = WORD_W * WORDS_PER_LINE;
  localparam int WIDX_W         = $clog2(WORDS_PER_LINE);

  typedef enum logic {REG_DATA = 1'b0, REG_COUNT = 1'b1} reg_sel_e;

  // Most significant word has index 0.
  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] line,
                                                input logic [WIDX_W-1:0] idx);
    return line[(WORDS_PER_LINE - 1 - int'(idx)) * WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              arm_rise_i,
  input  logic              cap_valid_i,
  input  logic [LINE_W-1:0] cap_line_i,
  input  logic [PTR_W-1:0]  rd_line_i,
  output logic [LINE_W-1:0] rd_line_data_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic [LINE_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  base_ptr;
  logic [CNT_W-1:0]  base_cnt;
  logic              base_ovf;
  logic              do_write;
  logic              full;

  assign base_ptr = arm_rise_i ? '0 : wr_ptr_o;
  assign base_cnt = arm_rise_i ? '0 : cnt_o;
  assign base_ovf = arm_rise_i ? 1'b0 : ovf_o;
  assign do_write = arm_i && cap_valid_i;
  assign full     = (base_cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_o <= '0;
      cnt_o    <= '0;
      ovf_o    <= 1'b0;
    end else if (do_write) begin
      wr_ptr_o <= (base_ptr == PTR_W'(DEPTH - 1)) ? '0 : base_ptr + 1'b1;
      cnt_o    <= full ? base_cnt : base_cnt + 1'b1;
      ovf_o    <= base_ovf | full;
    end else begin
      wr_ptr_o <= base_ptr;
      cnt_o    <= base_cnt;
      ovf_o    <= base_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) store[base_ptr] <= cap_line_i;
  end

  assign rd_line_data_o = store[rd_line_i];
endmodule

// File: rtl/trace_access_gate.sv
module trace_access_gate
  import trace_pkg::*;
#(
  parameter int SRC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [SRC_N-1:0] src_en_i,
  input  logic             secure_i,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic             bus_reg_i,
  input  logic             bus_odd_i,
  input  logic             bus_byte_i,
  output logic             rd_req_o,
  output logic             cnt_rd_o,
  output logic             data_ok_o,
  output logic             rewind_o
);
  logic     unlocked;
  logic     aligned;
  logic     is_data;
  logic     readable;
  reg_sel_e sel;

  assign sel      = reg_sel_e'(bus_reg_i);
  assign is_data  = (sel == REG_DATA);
  assign aligned  = !bus_odd_i && !bus_byte_i;
  assign readable = unlocked && !arm_i && (|src_en_i) && !secure_i;

  assign rd_req_o  = bus_req_i && !bus_we_i;
  assign cnt_rd_o  = rd_req_o && (sel == REG_COUNT);
  assign data_ok_o = rd_req_o && is_data && aligned && readable;
  assign rewind_o  = bus_req_i && bus_we_i && is_data && aligned && !arm_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        unlocked <= 1'b0;
    else if (arm_i)    unlocked <= 1'b0;
    else if (rewind_o) unlocked <= 1'b1;
  end
endmodule

// File: rtl/trace_read_ptr.sv
module trace_read_ptr
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rewind_i,
  input  logic              arm_fall_i,
  input  logic              advance_i,
  input  logic              ovf_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  output logic [PTR_W-1:0]  line_o,
  output logic [WIDX_W-1:0] word_o
);
  logic [PTR_W-1:0] oldest;

  // After a wrap the write position holds the oldest line.
  assign oldest = ovf_i ? wr_ptr_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o <= '0;
      word_o <= '0;
    end else if (rewind_i || arm_fall_i) begin
      line_o <= oldest;
      word_o <= '0;
    end else if (advance_i) begin
      if (word_o == WIDX_W'(WORDS_PER_LINE - 1)) begin
        word_o <= '0;
        line_o <= (line_o == PTR_W'(DEPTH - 1)) ? '0 : line_o + 1'b1;
      end else begin
        word_o <= word_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_readout.sv
module trace_readout
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SRC_N = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [SRC_N-1:0]  src_en_i,
  input  logic              secure_i,
  input  logic              cap_valid_i,
  input  logic [LINE_W-1:0] cap_line_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_reg_i,
  input  logic              bus_odd_i,
  input  logic              bus_byte_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic              arm_q;
  logic              arm_rise;
  logic              arm_fall;
  logic              rd_req;
  logic              cnt_rd;
  logic              data_ok;
  logic              rewind;
  logic [PTR_W-1:0]  wr_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              ovf;
  logic [PTR_W-1:0]  rd_line;
  logic [WIDX_W-1:0] rd_word;
  logic [LINE_W-1:0] line_data;
  logic [WORD_W-1:0] cnt_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_i;
  end

  assign arm_rise = arm_i && !arm_q;
  assign arm_fall = !arm_i && arm_q;

  trace_capture #(.DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .arm_rise_i(arm_rise),
    .cap_valid_i(cap_valid_i), .cap_line_i(cap_line_i), .rd_line_i(rd_line),
    .rd_line_data_o(line_data), .wr_ptr_o(wr_ptr), .cnt_o(cnt), .ovf_o(ovf)
  );

  trace_access_gate #(.SRC_N(SRC_N)) u_gate (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .src_en_i(src_en_i),
    .secure_i(secure_i), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
    .bus_reg_i(bus_reg_i), .bus_odd_i(bus_odd_i), .bus_byte_i(bus_byte_i),
    .rd_req_o(rd_req), .cnt_rd_o(cnt_rd), .data_ok_o(data_ok), .rewind_o(rewind)
  );

  trace_read_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .rewind_i(rewind), .arm_fall_i(arm_fall),
    .advance_i(data_ok), .ovf_i(ovf), .wr_ptr_i(wr_ptr),
    .line_o(rd_line), .word_o(rd_word)
  );

  assign cnt_word = {ovf, {(WORD_W - 1 - CNT_W){1'b0}}, cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req;
      if (cnt_rd)       rd_data_o <= cnt_word;
      else if (data_ok) rd_data_o <= word_of(line_data, rd_word);
      else              rd_data_o <= '0;
    end
  end
endmodule

// File: rtl/trace_readout_chk.sv
module trace_readout_chk
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_rise,
  input logic              arm_fall,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic              bus_reg_i,
  input logic              bus_odd_i,
  input logic              bus_byte_i,
  input logic              data_ok,
  input logic              rewind,
  input logic              rd_valid_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [PTR_W-1:0]  rd_line,
  input logic [WIDX_W-1:0] rd_word,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf
);
  // R11
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && !bus_we_i) |=> rd_valid_o);

  // R4
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && !bus_we_i && !bus_reg_i && !data_ok) |=> (rd_data_o == '0));

  // R6
  narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && !bus_we_i && (bus_odd_i || bus_byte_i) && !arm_fall)
      |=> ($stable(rd_line) && $stable(rd_word)));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  // R2
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt == CNT_W'(DEPTH)));

  // R3
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_rise |=> (cnt <= CNT_W'(1) && !ovf));

  // R5
  rewind_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (rd_word == '0));

  // R7
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok && rd_word != WIDX_W'(WORDS_PER_LINE - 1))
      |=> (rd_word == $past(rd_word) + 1'b1));
endmodule

bind trace_readout trace_readout_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_rise(arm_rise), .arm_fall(arm_fall),
  .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_reg_i(bus_reg_i),
  .bus_odd_i(bus_odd_i), .bus_byte_i(bus_byte_i), .data_ok(data_ok),
  .rewind(rewind), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
  .rd_line(rd_line), .rd_word(rd_word), .cnt(cnt), .ovf(ovf)
);

// File: tb/tb_trace_readout.sv
`timescale 1ns/1ps
module tb_trace_readout;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [1:0]  src_en = 2'b01;
  logic        secure = 1'b0;
  logic        cap_valid = 1'b0;
  logic [63:0] cap_line = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_reg = 1'b0, bus_odd = 1'b0, bus_byte = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int fails = 0;

  // reference model
  logic [63:0] m_mem [DEPTH];
  int m_wr = 0, m_cnt = 0, m_line = 0, m_word = 0;
  bit m_ovf = 0, m_unlock = 0;

  always #4 clk = ~clk;

  trace_readout #(.DEPTH(DEPTH), .SRC_N(2)) dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .src_en_i(src_en), .secure_i(secure),
    .cap_valid_i(cap_valid), .cap_line_i(cap_line), .bus_req_i(bus_req),
    .bus_we_i(bus_we), .bus_reg_i(bus_reg), .bus_odd_i(bus_odd),
    .bus_byte_i(bus_byte), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic logic [15:0] exp_count();
    return (16'(m_ovf) << 15) | 16'(m_cnt);
  endfunction

  function automatic logic [15:0] exp_word(logic [63:0] line, int idx);
    logic [63:0] sh;
    sh = line >> (16 * (3 - idx));
    return sh[15:0];
  endfunction

  function automatic bit granted(bit odd, bit byt);
    return m_unlock && !arm && (src_en != 2'b00) && !secure && !odd && !byt;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    m_wr = 0; m_cnt = 0; m_ovf = 0; m_unlock = 0;
  endtask

  task automatic do_disarm();
    @(negedge clk) arm = 1'b0;
    m_line = m_ovf ? m_wr : 0;
    m_word = 0;
  endtask

  task automatic capture(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap_valid = 1'b1;
      cap_line = {$urandom, $urandom};
      m_mem[m_wr] = cap_line;
      if (m_cnt == DEPTH) m_ovf = 1; else m_cnt++;
      m_wr = (m_wr + 1) % DEPTH;
    end
    @(negedge clk) cap_valid = 1'b0;
  endtask

  task automatic data_write(bit odd, bit byt);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_reg = 0; bus_odd = odd; bus_byte = byt;
    if (!arm && !odd && !byt) begin
      m_unlock = 1;
      m_line = m_ovf ? m_wr : 0;
      m_word = 0;
    end
    @(negedge clk) bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(string tag, bit reg_sel, bit odd, bit byt);
    logic [15:0] exp;
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_reg = reg_sel; bus_odd = odd; bus_byte = byt;
    if (reg_sel) exp = exp_count();
    else if (granted(odd, byt)) begin
      exp = exp_word(m_mem[m_line], m_word);
      m_word++;
      if (m_word == 4) begin m_word = 0; m_line = (m_line + 1) % DEPTH; end
    end else exp = 16'h0;
    @(negedge clk);
    bus_req = 0;
    chk("R11 valid", {15'b0, rd_valid}, 16'h1);
    chk(tag, rd_data, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset valid", {15'b0, rd_valid}, 16'h0);
    chk("R11 reset data", rd_data, 16'h0);
    bus_read("R2 reset count", 1, 0, 0);
    bus_read("R4 locked after reset", 0, 0, 0);

    // overflow session: 11 lines into 8
    do_arm();
    capture(DEPTH + 3);
    bus_read("R2 saturated count", 1, 0, 0);
    data_write(0, 0);                       // armed write, R9
    do_disarm();
    bus_read("R9 armed write ignored", 0, 0, 0);
    data_write(0, 1);
    bus_read("R9 byte write ignored", 0, 0, 0);
    data_write(1, 0);
    bus_read("R9 odd write ignored", 0, 0, 0);
    bus_read("R10 count while locked", 1, 0, 0);
    data_write(0, 0);
    bus_read("R8 oldest after wrap", 0, 0, 0);
    for (int i = 1; i < 4 * DEPTH + 4; i++) bus_read("R1 R7 wrapped readout", 0, 0, 0);
    bus_read("R10 count after reads", 1, 0, 0);

    // short session, no overflow
    do_arm();
    bus_read("R3 count cleared", 1, 0, 0);
    capture(5);
    do_disarm();
    data_write(0, 0);
    bus_read("R8 line0 first", 0, 0, 0);
    bus_read("R7 second word", 0, 0, 0);
    bus_read("R6 byte read", 0, 0, 1);
    bus_read("R6 odd read", 0, 1, 0);
    bus_read("R7 third word", 0, 0, 0);
    secure = 1;
    bus_read("R4 secured", 0, 0, 0);
    secure = 0;
    src_en = 2'b00;
    bus_read("R4 no source", 0, 0, 0);
    src_en = 2'b10;
    bus_read("R7 fourth word", 0, 0, 0);
    bus_read("R7 next line", 0, 0, 0);
    data_write(0, 0);
    bus_read("R5 rewind", 0, 0, 0);
    for (int i = 0; i < 4 * DEPTH; i++) bus_read("R7 past count", 0, 0, 0);
    bus_read("R10 count kept", 1, 0, 0);

    // random sessions
    for (int s = 0; s < 8; s++) begin
      do_arm();
      capture(1 + $urandom % 20);
      bus_read("R2 count armed", 1, 0, 0);
      bus_read("R4 armed read", 0, 0, 0);
      do_disarm();
      if ($urandom % 2) data_write(0, 0);
      for (int k = 0; k < 40; k++) begin
        case ($urandom % 10)
          0, 1, 2, 3: bus_read("R7 random word", 0, 0, 0);
          4: bus_read("R6 random byte", 0, 0, 1);
          5: bus_read("R6 random odd", 0, 1, 0);
          6: data_write(0, 0);
          7: begin data_write($urandom % 2, 1); bus_read("R9 random narrow write", 0, 0, 0); end
          8: begin
               secure = ($urandom % 4 == 0);
               src_en = ($urandom % 4 == 0) ? 2'b00 : 2'(1 + $urandom % 3);
               bus_read("R4 random gate", 0, 0, 0);
             end
          default: bus_read("R10 random count", 1, 0, 0);
        endcase
      end
      secure = 0;
      src_en = 2'b01;
    end

    summary();
    $finish;
  end
endmodule